// File: doc/BRIEF.md
# Gated 16-bit Timer/Counter

This block is a 16-bit up-counter held as two byte registers, a low byte and a high byte, that software can write and read one at a time over a small byte-wide register port. Each count step comes from one of two places. In timer mode it is a one-cycle tick input from elsewhere in the chip. In counter mode it is a falling edge seen on an asynchronous external pin.

Counting needs a run bit in the control register. When a gate option is also set, counting further needs an external gate pin to be high, so an outside signal can measure how long it stays high. When the count steps past its all-ones value it wraps to zero and keeps going. At the same time it sets a sticky overflow flag, which only software clears.

Top module: `gated_timer16`

## Requirements
- R1: After reset, the low byte, the high byte, the control bits and the overflow flag are all 0, and `ovf_flag` is 0.
- R2: A write with `wr_en` high and `addr` = 0 loads `wdata` into the low byte; `addr` = 1 loads the high byte. `rd_data` shows the addressed register combinationally in the same cycle.
- R3: The control register is at `addr` = 2: bit 0 is run, bit 1 is source (0 = tick, 1 = external pin), bit 2 is gate option, bit 3 is the overflow flag, and bits 7:4 read as 0. `addr` = 3 reads as 0.
- R4: In timer mode, while counting is enabled, the 16-bit count rises by exactly one at each clock edge where `tick` is high. `tick` has no effect in counter mode.
- R5: In counter mode, each 1-to-0 transition of `cnt_pin` adds exactly one count, within four cycles. The pin passes two synchronizing flops before edge detection. Rising edges add nothing.
- R6: Counting is enabled only when run is 1 and either the gate option is 0 or `gate_pin` is high. `gate_pin` passes two synchronizing flops. With run 0, or with the gate option set and the gate low, the count holds.
- R7: A step taken at count FFFFh makes the count 0000h and sets the overflow flag. Later enabled steps keep counting up from 0000h.
- R8: The overflow flag stays set until a write to the control register with bit 3 = 0. Writing 1 to bit 3 never sets it. If an overflow and a clearing write happen in the same cycle, the flag ends set.
- R9: A write to either byte register in a cycle where a step would occur takes priority: the written byte takes `wdata`, the other byte keeps its value, and no increment happens.
- R10: `ovf_flag` always equals the overflow flag bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 low byte, 1 high byte, 2 control |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data of the addressed register |
| tick | input | 1 | Internal count tick for timer mode |
| cnt_pin | input | 1 | Asynchronous external count input |
| gate_pin | input | 1 | Asynchronous external gate input |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The hardest cases to reach from the ports are collisions inside one clock edge. One is a software write landing on the same edge as an increment. The other is an overflow landing on the same edge as a flag-clearing write. The stimulus gets there by holding `tick` high only for the single cycle in which the write task raises `wr_en`, after first loading the count with FFFFh or another chosen value. Timer-mode counts are exact because `tick` is driven only by the stimulus, while pin edges and gate changes are given several idle cycles to cross the synchronizers before the next read.

// File: rtl/gated_timer16.sv
module gated_timer16 #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              tick,
  input  logic              cnt_pin,
  input  logic              gate_pin,
  output logic              ovf_flag
);
  localparam int CNT_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] lo_q, hi_q;
  logic              run_q, ext_q, gate_en_q, ovf_q;
  logic [2:0]        pin_sh;
  logic [1:0]        gate_sh;

  logic [CNT_W-1:0]  count;
  logic              wr_lo, wr_hi, wr_ctl, byte_wr;
  logic              pin_fall, enabled, step, ovf_set;

  assign count    = {hi_q, lo_q};
  assign wr_lo    = wr_en && addr == 2'd0;
  assign wr_hi    = wr_en && addr == 2'd1;
  assign wr_ctl   = wr_en && addr == 2'd2;
  assign byte_wr  = wr_lo || wr_hi;
  assign pin_fall = pin_sh[2] && !pin_sh[1];
  assign enabled  = run_q && (!gate_en_q || gate_sh[1]);
  assign step     = enabled && (ext_q ? pin_fall : tick);
  assign ovf_set  = step && !byte_wr && (&count);
  assign ovf_flag = ovf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_sh  <= '0;
      gate_sh <= '0;
    end else begin
      pin_sh  <= {pin_sh[1:0], cnt_pin};
      gate_sh <= {gate_sh[0], gate_pin};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (byte_wr) begin
      if (wr_lo) lo_q <= wdata;
      if (wr_hi) hi_q <= wdata;
    end else if (step) begin
      {hi_q, lo_q} <= count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      ext_q     <= 1'b0;
      gate_en_q <= 1'b0;
    end else if (wr_ctl) begin
      run_q     <= wdata[0];
      ext_q     <= wdata[1];
      gate_en_q <= wdata[2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     ovf_q <= 1'b0;
    else if (ovf_set)               ovf_q <= 1'b1;
    else if (wr_ctl && !wdata[3])   ovf_q <= 1'b0;
  end

  always_comb begin
    rd_data = '0;
    case (addr)
      2'd0: rd_data = lo_q;
      2'd1: rd_data = hi_q;
      2'd2: rd_data[3:0] = {ovf_q, gate_en_q, ext_q, run_q};
      default: rd_data = '0;
    endcase
  end
endmodule

module gated_timer16_chk #(
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [1:0]    addr,
  input logic [BW-1:0] wdata,
  input logic [2*BW-1:0] count,
  input logic          flag,
  input logic          step,
  input logic          run,
  input logic          gate_en,
  input logic          gate_s
);
  logic [2*BW-1:0] count_inc;
  logic            bwr;
  assign count_inc = count + 1'b1;
  assign bwr = wr_en && !addr[1];

  assert_step_max_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !bwr |=> (count == $past(count) || count == $past(count_inc)));

  assert_gate_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && gate_en && !gate_s && !bwr) |=> $stable(count));

  assert_run_off_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !bwr) |=> $stable(count));

  assert_wrap_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && (&count) && !bwr) |=> (count == '0 && flag));

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(wr_en && addr == 2'd2 && !wdata[3])) |=> flag);

  assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0) |=> (count[BW-1:0] == $past(wdata)));
endmodule

bind gated_timer16 gated_timer16_chk #(.BW(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .count(count), .flag(ovf_q), .step(step), .run(run_q),
  .gate_en(gate_en_q), .gate_s(gate_sh[1])
);

// File: tb/test_gated_timer16.sv
module test_gated_timer16;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rd_data;
  logic       tick = 1'b0;
  logic       cnt_pin = 1'b1;
  logic       gate_pin = 1'b0;
  logic       ovf_flag;

  gated_timer16 i_gated_timer16 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rd_data(rd_data), .tick(tick), .cnt_pin(cnt_pin), .gate_pin(gate_pin),
    .ovf_flag(ovf_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [8:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  logic  mon_req = 1'b0;
  int    total = 0;
  int    bad = 0;
  bit    done = 1'b0;

  always @(negedge clk) begin
    if (mon_req && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      total++;
      if ({ovf_flag, rd_data} !== it.exp) begin
        bad++;
        $display("FAIL %s: got flag=%0b data=%02h, expected flag=%0b data=%02h",
                 it.tag, ovf_flag, rd_data, it.exp[8], it.exp[7:0]);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic tk = 1'b0);
    @(posedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d; tick = tk;
    @(posedge clk); #1;
    wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(posedge clk); #1 tick = 1'b1;
    repeat (n) @(posedge clk);
    #1 tick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input logic f, input string tag);
    item_t it;
    @(posedge clk); #1;
    addr = a;
    it.exp = {f, e};
    it.tag = tag;
    q.push_back(it);
    mon_req = 1'b1;
    @(negedge clk); #1 mon_req = 1'b0;
  endtask

  task automatic pin_pulse_low();
    @(posedge clk); #1 cnt_pin = 1'b0;
    idle(4);
    #1 cnt_pin = 1'b1;
    idle(4);
  endtask

  initial begin
    idle(3);
    #1 rst_n = 1'b1;
    idle(2);

    rd(2'd0, 8'h00, 1'b0, "R1 low byte after reset");
    rd(2'd1, 8'h00, 1'b0, "R1 high byte after reset");
    rd(2'd2, 8'h00, 1'b0, "R1 control after reset");

    wr(2'd0, 8'h34); wr(2'd1, 8'h12);
    rd(2'd0, 8'h34, 1'b0, "R2 low byte write");
    rd(2'd1, 8'h12, 1'b0, "R2 high byte write");

    ticks(3);
    rd(2'd0, 8'h34, 1'b0, "R6 run off holds count");

    wr(2'd2, 8'h01);
    rd(2'd2, 8'h01, 1'b0, "R3 control readback run");
    ticks(5);
    rd(2'd0, 8'h39, 1'b0, "R4 five ticks low");
    rd(2'd1, 8'h12, 1'b0, "R4 five ticks high");

    wr(2'd2, 8'h03);
    rd(2'd2, 8'h03, 1'b0, "R3 control source bit");
    ticks(3);
    rd(2'd0, 8'h39, 1'b0, "R4 tick ignored in counter mode");
    pin_pulse_low();
    pin_pulse_low();
    rd(2'd0, 8'h3B, 1'b0, "R5 two falling edges");

    wr(2'd2, 8'h05);
    gate_pin = 1'b0;
    idle(3);
    ticks(3);
    rd(2'd0, 8'h3B, 1'b0, "R6 gate low blocks");
    #1 gate_pin = 1'b1;
    idle(3);
    ticks(2);
    rd(2'd0, 8'h3D, 1'b0, "R6 gate high counts");
    #1 gate_pin = 1'b0;
    wr(2'd2, 8'h01);
    idle(3);
    ticks(1);
    rd(2'd0, 8'h3E, 1'b0, "R6 gate option off ignores pin");

    wr(2'd0, 8'hFE); wr(2'd1, 8'hFF);
    ticks(2);
    rd(2'd0, 8'h00, 1'b1, "R7 wrap low");
    rd(2'd1, 8'h00, 1'b1, "R7 wrap high");
    rd(2'd2, 8'h09, 1'b1, "R10 flag bit and pin");
    ticks(1);
    rd(2'd0, 8'h01, 1'b1, "R7 keeps counting after wrap");

    wr(2'd2, 8'h09);
    rd(2'd2, 8'h09, 1'b1, "R8 writing one keeps flag");
    wr(2'd2, 8'h01);
    rd(2'd2, 8'h01, 1'b0, "R8 writing zero clears flag");
    wr(2'd2, 8'h09);
    rd(2'd2, 8'h01, 1'b0, "R8 writing one does not set flag");

    wr(2'd0, 8'h50, 1'b1);
    rd(2'd0, 8'h50, 1'b0, "R9 low write beats increment");
    rd(2'd1, 8'h00, 1'b0, "R9 high byte kept");
    wr(2'd1, 8'hAA, 1'b1);
    rd(2'd1, 8'hAA, 1'b0, "R9 high write beats increment");
    rd(2'd0, 8'h50, 1'b0, "R9 low byte kept");

    wr(2'd0, 8'hFF); wr(2'd1, 8'hFF);
    wr(2'd2, 8'h01, 1'b1);
    rd(2'd2, 8'h09, 1'b1, "R8 overflow wins over clear");
    rd(2'd0, 8'h00, 1'b1, "R7 wrap on collision cycle");
    rd(2'd3, 8'h00, 1'b1, "R3 unused address reads zero");

    idle(2);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: got running, expected finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule